// File: doc/BRIEF.md
# Priority Interrupt Controller with Software Force

This block collects interrupt requests for fifteen levels, numbered 1 to 15, and presents the processor with one 4-bit number: the highest level that is active and enabled. A level is active when its latched request bit or its software force bit is set. It is enabled when its enable bit is set. Peripherals raise requests with one-cycle pulses on a 16-line input vector. The processor takes an interrupt by sending back an acknowledge strobe that carries the level it took.

Software controls the block through a 32-bit register bus with no wait states. It can enable levels, inspect the latched requests, drop latched requests in bulk, and raise any level by itself through the force register. An acknowledge removes a forced request before it touches a latched one. So a level that is both forced and latched is served twice.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Byte offsets on `bus_addr`: 0x90 enable, 0x94 latched, 0x98 force, 0x9C clear. The first three read back in bits 15:0 of `bus_rdata`, and bits 31:16 are zero. Reading the clear offset or any other offset gives zero, and a write to an unlisted offset changes nothing. `bus_rdata` is zero unless `bus_sel` is high and `bus_write` is low.
- R2: The reported level is the index of the highest set bit among bits 1..15 of ((latched OR force) AND enable). It is 0 when no such bit is set.
- R3: `irq_level` is a register. A stimulus sampled at clock edge k changes the request registers at edge k, and the reported level follows at edge k+1.
- R4: An acknowledge of level n with force bit n set clears only force bit n. Otherwise it clears latched bit n.
- R5: A write to the clear offset clears each latched bit in 1..15 whose data bit is 1.
- R6: A write to the enable offset stores the data AND 0x7FFE, so enable bits 0 and 15 always read 0 and level 15 is never reported.
- R7: A write to the force offset stores the data AND 0xFFFE. Such a write overrides an acknowledge-driven force clear in the same cycle.
- R8: A pulse on `irq_pulse[i]`, with i in 1..15, sets latched bit i. This set wins over a clear-offset write or an acknowledge in the same cycle. Line 0 is ignored.
- R9: Reset clears the enable, latched and force registers and drives `irq_level` to 0.
- R10: An acknowledge with `ack_valid` low, or with level 0, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_pulse | input | 16 | One-cycle request pulses, line 0 unused |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_level | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Highest active enabled level, 0 for none |

## Verification
A peripheral pulse can land in the same cycle as a software clear or an acknowledge of the same bit. Likewise, a force-register write can coincide with an acknowledge that would clear that force bit. The bench builds these collisions on purpose: a pulse during a clear-all write, an acknowledge together with a force write, and a forced-plus-latched level acknowledged twice. It then judges the result by reading the registers back and by watching the level one cycle later. A random phase mixes pulses, acknowledges and writes freely, and a behavioural model checks the level and read data on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NLINES = 16;
  localparam int LVL_W  = $clog2(NLINES);
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h90;
  localparam logic [ADDR_W-1:0] OFS_LATCH  = 8'h94;
  localparam logic [ADDR_W-1:0] OFS_FORCE  = 8'h98;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 8'h9C;

  localparam logic [NLINES-1:0] LINE_KEEP   = 16'hFFFE;
  localparam logic [NLINES-1:0] FORCE_KEEP  = 16'hFFFE;
  localparam logic [NLINES-1:0] ENABLE_KEEP = 16'h7FFE;

  typedef logic [NLINES-1:0] irq_vec_t;

  typedef struct packed {
    logic enable_we;
    logic force_we;
    logic clear_we;
  } bus_wr_t;

  // highest set bit among 1..NLINES-1, zero when none
  function automatic logic [LVL_W-1:0] top_level(irq_vec_t v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 1; i < NLINES; i++)
      if (v[i]) r = i[LVL_W-1:0];
    return r;
  endfunction

  // one-hot of a level, level 0 maps to no bit
  function automatic irq_vec_t level_onehot(logic [LVL_W-1:0] l);
    irq_vec_t o;
    o = '0;
    o[l] = 1'b1;
    o[0] = 1'b0;
    return o;
  endfunction
endpackage

// File: rtl/irq_bus_if.sv
module irq_bus_if
  import irq_pkg::*;
(
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  irq_vec_t          enable_q,
  input  irq_vec_t          latch_q,
  input  irq_vec_t          force_q,
  output bus_wr_t           wr,
  output irq_vec_t          wr_vec,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int PAD_W = DATA_W - NLINES;

  logic     do_wr, do_rd;
  irq_vec_t rd_vec;

  assign do_wr  = bus_sel & bus_write;
  assign do_rd  = bus_sel & ~bus_write;
  assign wr_vec = bus_wdata[NLINES-1:0];

  always_comb begin
    wr.enable_we = do_wr && (bus_addr == OFS_ENABLE);
    wr.force_we  = do_wr && (bus_addr == OFS_FORCE);
    wr.clear_we  = do_wr && (bus_addr == OFS_CLEAR);
  end

  always_comb begin
    rd_vec = '0;
    if (do_rd) begin
      case (bus_addr)
        OFS_ENABLE: rd_vec = enable_q;
        OFS_LATCH:  rd_vec = latch_q;
        OFS_FORCE:  rd_vec = force_q;
        default:    rd_vec = '0;
      endcase
    end
  end

  assign bus_rdata = {{PAD_W{1'b0}}, rd_vec};
endmodule

// File: rtl/irq_ack_split.sv
module irq_ack_split
  import irq_pkg::*;
(
  input  logic             ack_valid,
  input  logic [LVL_W-1:0] ack_level,
  input  irq_vec_t         force_q,
  output irq_vec_t         force_clr,
  output irq_vec_t         latch_clr
);
  irq_vec_t hit;

  assign hit       = ack_valid ? level_onehot(ack_level) : '0;
  assign force_clr = hit & force_q;
  assign latch_clr = hit & ~force_q;
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bus_wr_t  wr,
  input  irq_vec_t wr_vec,
  input  irq_vec_t irq_pulse,
  input  irq_vec_t force_clr,
  input  irq_vec_t latch_clr,
  output irq_vec_t enable_q,
  output irq_vec_t latch_q,
  output irq_vec_t force_q,
  output irq_vec_t clear_vec
);
  assign clear_vec = wr.clear_we ? (wr_vec & LINE_KEEP) : '0;

  assign latch_q[0] = 1'b0;
  for (genvar g = 1; g < NLINES; g++) begin : g_latch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            latch_q[g] <= 1'b0;
      else if (irq_pulse[g]) latch_q[g] <= 1'b1;
      else if (clear_vec[g] || latch_clr[g]) latch_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           force_q <= '0;
    else if (wr.force_we) force_q <= wr_vec & FORCE_KEEP;
    else                  force_q <= force_q & ~force_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            enable_q <= '0;
    else if (wr.enable_we) enable_q <= wr_vec & ENABLE_KEEP;
  end
endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  irq_vec_t         enable_q,
  input  irq_vec_t         latch_q,
  input  irq_vec_t         force_q,
  output irq_vec_t         qualified,
  output logic [LVL_W-1:0] level_q
);
  assign qualified = (latch_q | force_q) & enable_q & LINE_KEEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= top_level(qualified);
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NLINES-1:0] irq_pulse,
  input  logic              ack_valid,
  input  logic [LVL_W-1:0]  ack_level,
  output logic [LVL_W-1:0]  irq_level
);
  bus_wr_t  wr;
  irq_vec_t wr_vec;
  irq_vec_t enable_q, latch_q, force_q;
  irq_vec_t force_clr, latch_clr, clear_vec, qualified;

  irq_bus_if u_bus (
    .bus_sel   (bus_sel),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .enable_q  (enable_q),
    .latch_q   (latch_q),
    .force_q   (force_q),
    .wr        (wr),
    .wr_vec    (wr_vec),
    .bus_rdata (bus_rdata)
  );

  irq_ack_split u_ack (
    .ack_valid (ack_valid),
    .ack_level (ack_level),
    .force_q   (force_q),
    .force_clr (force_clr),
    .latch_clr (latch_clr)
  );

  irq_state_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr),
    .wr_vec    (wr_vec),
    .irq_pulse (irq_pulse),
    .force_clr (force_clr),
    .latch_clr (latch_clr),
    .enable_q  (enable_q),
    .latch_q   (latch_q),
    .force_q   (force_q),
    .clear_vec (clear_vec)
  );

  irq_level_enc u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_q  (enable_q),
    .latch_q   (latch_q),
    .force_q   (force_q),
    .qualified (qualified),
    .level_q   (irq_level)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NLINES-1:0] irq_pulse,
  input irq_vec_t         enable_q,
  input irq_vec_t         latch_q,
  input irq_vec_t         force_q,
  input irq_vec_t         force_clr,
  input irq_vec_t         latch_clr,
  input logic             force_we,
  input logic [LVL_W-1:0] irq_level
);
  AST_ENABLE_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q[0] == 1'b0) && (enable_q[NLINES-1] == 1'b0)); // R6

  AST_LEVEL_NEVER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level != LVL_W'(NLINES-1)); // R6

  AST_FORCE_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    force_q[0] == 1'b0); // R7

  AST_PULSE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_pulse & LINE_KEEP) != '0) |=>
      ((latch_q & $past(irq_pulse) & LINE_KEEP) == ($past(irq_pulse) & LINE_KEEP))); // R8

  AST_ACK_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(force_clr | latch_clr)); // R4

  AST_ACK_DROPS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    ((force_clr != '0) && !force_we) |=> ((force_q & $past(force_clr)) == '0)); // R4

  AST_IDLE_LEVEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (((latch_q | force_q) & enable_q) == '0) |=> (irq_level == '0)); // R2
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_pulse (irq_pulse),
  .enable_q  (enable_q),
  .latch_q   (latch_q),
  .force_q   (force_q),
  .force_clr (force_clr),
  .latch_clr (latch_clr),
  .force_we  (wr.force_we),
  .irq_level (irq_level)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_pulse = 16'h0;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_level = 4'h0;
  logic [3:0]  irq_level;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (.*);

  // behavioural reference
  logic [15:0] m_en, m_lat, m_frc;
  logic [3:0]  m_lvl;

  function automatic logic [3:0] pick_level(logic [15:0] a);
    for (int k = 15; k >= 1; k--) if (a[k]) return 4'(k);
    return 4'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_lat <= 0; m_frc <= 0; m_lvl <= 0;
    end else begin
      logic [15:0] lat, frc;
      lat = m_lat; frc = m_frc;
      if (ack_valid && ack_level != 0) begin
        if (m_frc[ack_level]) frc[ack_level] = 1'b0;
        else                  lat[ack_level] = 1'b0;
      end
      if (bus_sel && bus_write) begin
        if (bus_addr == 8'h9C) lat = lat & ~(bus_wdata[15:0] & 16'hFFFE);
        if (bus_addr == 8'h98) frc = bus_wdata[15:0] & 16'hFFFE;
        if (bus_addr == 8'h90) m_en <= bus_wdata[15:0] & 16'h7FFE;
      end
      lat = lat | (irq_pulse & 16'hFFFE);
      m_lat <= lat;
      m_frc <= frc;
      m_lvl <= pick_level((m_lat | m_frc) & m_en);
    end
  end

  function automatic logic [31:0] model_rd();
    if (!(bus_sel && !bus_write)) return 0;
    case (bus_addr)
      8'h90: return {16'h0, m_en};
      8'h94: return {16'h0, m_lat};
      8'h98: return {16'h0, m_frc};
      default: return 0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // apply inputs, clock once, compare against the model
  task automatic step(input logic s, input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [15:0] p, input logic av, input logic [3:0] al);
    bus_sel = s; bus_write = w; bus_addr = a; bus_wdata = d;
    irq_pulse = p; ack_valid = av; ack_level = al;
    @(posedge clk); #1;
    chk({28'h0, irq_level}, {28'h0, m_lvl}, "R2 model level");
    chk(bus_rdata, model_rd(), "R1 model read");
  endtask

  task automatic idle(); step(0, 0, 8'h0, 0, 0, 0, 0); endtask
  task automatic wrt(input logic [7:0] a, input logic [31:0] d); step(1, 1, a, d, 0, 0, 0); endtask
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    step(1, 0, a, 0, 0, 0, 0);
    chk(bus_rdata, e, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9 reset state
    chk({28'h0, irq_level}, 0, "R9 level after reset");
    rd(8'h90, 0, "R9 enable after reset");
    rd(8'h94, 0, "R9 latched after reset");
    rd(8'h98, 0, "R9 force after reset");

    // R6 enable mask
    wrt(8'h90, 32'hFFFF_FFFF);
    rd(8'h90, 32'h7FFE, "R6 enable stores data AND 0x7FFE");
    // R7 force mask
    wrt(8'h98, 32'hFFFF_FFFF);
    rd(8'h98, 32'hFFFE, "R7 force stores data AND 0xFFFE");
    idle();
    chk({28'h0, irq_level}, 14, "R6 level 15 never reported");
    wrt(8'h98, 0);
    idle(); idle();
    chk({28'h0, irq_level}, 0, "R2 level 0 with nothing active");

    // R8 pulse, line 0 ignored; R3 timing
    step(0, 0, 0, 0, 16'h0021, 0, 0);
    chk({28'h0, irq_level}, 0, "R3 level not yet updated");
    step(1, 0, 8'h94, 0, 0, 0, 0);
    chk(bus_rdata, 32'h20, "R8 pulse latches, line 0 ignored");
    chk({28'h0, irq_level}, 5, "R3 level one cycle later");

    // R4 forced and latched: two acknowledges
    wrt(8'h98, 32'h20);
    idle();
    step(0, 0, 0, 0, 0, 1, 5);
    rd(8'h94, 32'h20, "R4 first ack keeps latched bit");
    rd(8'h98, 0, "R4 first ack clears force bit");
    chk({28'h0, irq_level}, 5, "R4 level still 5");
    step(0, 0, 0, 0, 0, 1, 5);
    rd(8'h94, 0, "R4 second ack clears latched bit");
    chk({28'h0, irq_level}, 0, "R4 level drops to 0");

    // R10 ack with valid low / level 0
    step(0, 0, 0, 0, 16'h0009, 0, 0);
    step(0, 0, 0, 0, 0, 0, 3);
    step(0, 0, 0, 0, 0, 1, 0);
    rd(8'h94, 32'h8, "R10 ignored acknowledges");
    chk({28'h0, irq_level}, 3, "R10 level unchanged");

    // R5 clear, R8 pulse beats clear
    step(1, 1, 8'h9C, 32'hFFFF, 16'h0010, 0, 0);
    rd(8'h94, 32'h10, "R8 pulse wins over clear write");
    wrt(8'h9C, 32'h0010);
    rd(8'h94, 0, "R5 clear write drops latched bit");
    // R8 pulse beats ack
    step(0, 0, 0, 0, 16'h0040, 0, 0);
    step(0, 0, 0, 0, 16'h0040, 1, 6);
    rd(8'h94, 32'h40, "R8 pulse wins over acknowledge");
    // R7 force write beats ack
    wrt(8'h98, 32'h0080);
    step(1, 1, 8'h98, 32'h0080, 0, 1, 7);
    rd(8'h98, 32'h80, "R7 force write overrides ack clear");
    rd(8'h94, 32'h40, "R7 ack did not touch latched bits");
    wrt(8'h98, 0);
    wrt(8'h9C, 32'hFFFF);

    // R1 decode
    wrt(8'h80, 32'hFFFF);
    rd(8'h94, 0, "R1 unlisted write has no effect");
    rd(8'h98, 0, "R1 unlisted write leaves force");
    rd(8'h9C, 0, "R1 clear offset reads zero");
    rd(8'hA0, 0, "R1 unlisted offset reads zero");
    wrt(8'h90, 32'hFFFF_0004);
    rd(8'h90, 32'h4, "R1 upper data bits dropped");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      logic [15:0] p;
      case ($urandom_range(0, 4))
        0: a = 8'h90; 1: a = 8'h94; 2: a = 8'h98; 3: a = 8'h9C; default: a = 8'h84;
      endcase
      p = ($urandom_range(0, 3) == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'h0;
      step($urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0, a,
           ($urandom_range(0, 3) == 0) ? $urandom() : 32'h0,
           p, $urandom_range(0, 2) == 0, 4'($urandom_range(0, 15)));
    end

    // R9 reset mid-run
    wrt(8'h90, 32'hFFFF);
    step(0, 0, 0, 0, 16'h0100, 0, 0);
    idle();
    #2 rst_n = 1'b0;
    #2 chk({28'h0, irq_level}, 0, "R9 level cleared by reset");
    @(posedge clk); #1 rst_n = 1'b1;
    rd(8'h94, 0, "R9 latched cleared by reset");
    rd(8'h90, 0, "R9 enable cleared by reset");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule